// File: doc/BRIEF.md
# Minimal-Adaptive Circuit-Switched Mesh Lane Switch

This block is one router of a two-dimensional mesh that carries streams between hardware modules over reserved circuits. Each router has four links to its neighbours and a parameter-set number of attached node ports. Every link and node port is split into parallel lanes, and each direction has its own lane count. A source asks the switch to open a circuit from one of its input lanes toward a destination router coordinate. The switch looks only at directions that bring the stream closer to the destination. Among those it takes the one with the most idle lanes, and it reserves the lowest-numbered idle lane there. From that point the input lane's data appears on the reserved output lane until the source releases it.

A request is answered in the cycle it is presented, with either a grant naming the output lane or a busy flag. Nothing is queued and nothing is half-reserved, so a source that sees busy simply retries later. If the destination is this router, the circuit goes straight to the output lanes of the named node port without touching a neighbour link. That lets two nodes on the same router talk directly.

Top module: `mesh_lane_switch`

## Requirements
- R1: After reset, every output lane is inactive and drives zero data.
- R2: In every cycle with `reqValid` high, exactly one of `respGrant` and `respBusy` is high in that same cycle. With `reqValid` low, both are low.
- R3: A granted lane always lies on a distance-reducing direction. Right is x+1, left is x-1, up is y+1 and down is y-1. When both coordinates equal the switch's own position, the lane lies on node port `reqDstNode`.
- R4: When both a horizontal and a vertical direction reduce the distance, the switch picks the one with more idle lanes. On equal counts it picks the horizontal one.
- R5: Within the chosen port, the grant names the lowest-numbered idle output lane. Output lanes are numbered right lanes first, then left, up, down, and then node ports 0, 1, and so on.
- R6: When the chosen port (or every candidate direction) has no idle lane, the request gets busy and no output lane changes state.
- R7: A request whose destination is this switch uses only the lanes of node port `reqDstNode`. A node index at or above the number of node ports gets busy.
- R8: An active output lane carries, in the same cycle, the data of the input lane that owns it. Input lanes are numbered like output lanes, but use the local input lane count. An idle output lane drives zero.
- R9: A release on an input lane that holds a circuit frees its output lane at the next clock edge. A request in the release cycle still sees the lane as taken. A release on an input lane holding nothing has no effect.
- R10: A request from an input lane that already holds a circuit, or from an index beyond the last input lane, gets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Circuit request present |
| reqInLane | input | IW | Input lane that asks for the circuit |
| reqDstX | input | CW | Destination router x coordinate |
| reqDstY | input | CW | Destination router y coordinate |
| reqDstNode | input | NW | Destination node port at the destination router |
| respGrant | output | 1 | Request granted this cycle |
| respBusy | output | 1 | Request refused this cycle |
| respOutLane | output | OW | Output lane reserved by the grant |
| relValid | input | 1 | Release request present |
| relInLane | input | IW | Input lane whose circuit is released |
| inData | input | NIN*W | Data of all input lanes, lane i at bits i*W upward |
| outData | output | NOUT*W | Data of all output lanes, lane o at bits o*W upward |
| outActive | output | NOUT | Output lane currently reserved |

## Verification
A lost or stale ownership entry shows at the ports within one cycle. An output lane either stays active with the wrong data behind it, or the next request gets a lane number, or a busy, that differs from the arithmetic expectation. Sweeping many requests and releases over a small switch shows this. A wrong free count in the direction choice shows at once as a grant on the other direction whenever the two candidates have unequal idle lanes. A release that lands a cycle early or late shows as a grant, or busy, in the cycle right after the release.

// File: rtl/mesh_lane_switch_pkg.sv
package mesh_lane_switch_pkg;
  // wide enough for any lane index the switch can be built with
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    DIR_RIGHT = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_UP    = 2'd2,
    DIR_DOWN  = 2'd3
  } dir_e;

  // strobes from the allocator to the lane table
  typedef struct packed {
    logic             take;
    logic [IDX_W-1:0] takeIn;
    logic [IDX_W-1:0] takeOut;
    logic             drop;
    logic [IDX_W-1:0] dropIn;
  } laneStrobe_t;
endpackage

// File: rtl/mesh_lane_switch_ctrl.sv
module mesh_lane_switch_ctrl
  import mesh_lane_switch_pkg::*;
#(
  parameter int KR = 2,
  parameter int KL = 1,
  parameter int KU = 3,
  parameter int KD = 2,
  parameter int NNODE = 2,
  parameter int KLI = 1,
  parameter int KLO = 2,
  parameter int MY_X = 2,
  parameter int MY_Y = 1,
  parameter int CW = 3,
  parameter int NW = 3,
  parameter int NIN = 10,
  parameter int NOUT = 12,
  parameter int IW = 4,
  parameter int OW = 4
) (
  input  logic            reqValid,
  input  logic [IW-1:0]   reqInLane,
  input  logic [CW-1:0]   reqDstX,
  input  logic [CW-1:0]   reqDstY,
  input  logic [NW-1:0]   reqDstNode,
  input  logic            relValid,
  input  logic [IW-1:0]   relInLane,
  input  logic [NOUT-1:0] laneFree,
  input  logic [NIN-1:0]  inLaneIdle,
  output logic            respGrant,
  output logic            respBusy,
  output logic [OW-1:0]   respOutLane,
  output laneStrobe_t     strb
);
  localparam int OFF_L = KR;
  localparam int OFF_U = KR + KL;
  localparam int OFF_D = KR + KL + KU;
  localparam int OFF_N = KR + KL + KU + KD;
  localparam logic [CW-1:0] HOME_X = CW'(MY_X);
  localparam logic [CW-1:0] HOME_Y = CW'(MY_Y);

  function automatic int countFree(input logic [NOUT-1:0] fv, input int base, input int cnt);
    int n;
    n = 0;
    for (int o = 0; o < NOUT; o++)
      if (o >= base && o < base + cnt && fv[o]) n++;
    return n;
  endfunction

  logic hWant, vWant, atHome, selOk, found, laneOk, relHeld, hit;
  int   hBase, hCnt, vBase, vCnt, hFree, vFree, selBase, selCnt, pick;

  always_comb begin
    hWant = 1'b0; hBase = 0; hCnt = 0;
    vWant = 1'b0; vBase = 0; vCnt = 0;
    // R3: only distance-reducing directions are candidates
    if (reqDstX > HOME_X) begin
      hWant = 1'b1; hBase = 0; hCnt = KR;
    end else if (reqDstX < HOME_X) begin
      hWant = 1'b1; hBase = OFF_L; hCnt = KL;
    end
    if (reqDstY > HOME_Y) begin
      vWant = 1'b1; vBase = OFF_U; vCnt = KU;
    end else if (reqDstY < HOME_Y) begin
      vWant = 1'b1; vBase = OFF_D; vCnt = KD;
    end
    hFree  = hWant ? countFree(laneFree, hBase, hCnt) : 0;
    vFree  = vWant ? countFree(laneFree, vBase, vCnt) : 0;
    atHome = !hWant && !vWant;

    selOk = 1'b0; selBase = 0; selCnt = 0;
    if (atHome) begin
      // R7: local delivery straight to a node port
      selOk   = int'(reqDstNode) < NNODE;
      selBase = OFF_N + int'(reqDstNode) * KLO;
      selCnt  = KLO;
    end else if (hFree != 0 && hFree >= vFree) begin
      // R4: most idle lanes wins, horizontal on a tie
      selOk = 1'b1; selBase = hBase; selCnt = hCnt;
    end else if (vFree != 0) begin
      selOk = 1'b1; selBase = vBase; selCnt = vCnt;
    end

    // R5: lowest idle lane inside the chosen port
    found = 1'b0; pick = 0;
    for (int o = NOUT - 1; o >= 0; o--)
      if (o >= selBase && o < selBase + selCnt && laneFree[o]) begin
        found = 1'b1; pick = o;
      end

    laneOk  = (int'(reqInLane) < NIN) ? inLaneIdle[reqInLane] : 1'b0;   // R10
    relHeld = (int'(relInLane) < NIN) ? !inLaneIdle[relInLane] : 1'b0;  // R9
    hit     = reqValid && laneOk && selOk && found;

    respGrant   = hit;
    respBusy    = reqValid && !hit;  // R6
    respOutLane = OW'(pick);

    strb.take    = hit;
    strb.takeIn  = IDX_W'(reqInLane);
    strb.takeOut = IDX_W'(pick);
    strb.drop    = relValid && relHeld;
    strb.dropIn  = IDX_W'(relInLane);
  end
endmodule

// File: rtl/mesh_lane_switch_path.sv
module mesh_lane_switch_path
  import mesh_lane_switch_pkg::*;
#(
  parameter int W = 16,
  parameter int NIN = 10,
  parameter int NOUT = 12,
  parameter int IW = 4,
  parameter int OW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  laneStrobe_t     strb,
  input  logic [NIN*W-1:0]  inData,
  output logic [NOUT*W-1:0] outData,
  output logic [NOUT-1:0] outHeld,
  output logic [NIN-1:0]  inHeld
);
  logic [IW-1:0] outSrc [NOUT];
  logic [OW-1:0] inDst  [NIN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outHeld <= '0;
      inHeld  <= '0;
      for (int o = 0; o < NOUT; o++) outSrc[o] <= '0;
      for (int i = 0; i < NIN; i++) inDst[i] <= '0;
    end else begin
      // R9: a release clears both sides of the circuit at this edge
      if (strb.drop) begin
        inHeld[IW'(strb.dropIn)]           <= 1'b0;
        outHeld[inDst[IW'(strb.dropIn)]]   <= 1'b0;
      end
      if (strb.take) begin
        inHeld[IW'(strb.takeIn)]   <= 1'b1;
        outHeld[OW'(strb.takeOut)] <= 1'b1;
        outSrc[OW'(strb.takeOut)]  <= IW'(strb.takeIn);
        inDst[IW'(strb.takeIn)]    <= OW'(strb.takeOut);
      end
    end
  end

  // R8: reserved lanes pass their owner's data, idle lanes drive zero
  always_comb begin
    for (int o = 0; o < NOUT; o++)
      outData[o*W +: W] = outHeld[o] ? inData[int'(outSrc[o])*W +: W] : '0;
  end
endmodule

// File: rtl/mesh_lane_switch.sv
module mesh_lane_switch
  import mesh_lane_switch_pkg::*;
#(
  parameter int W = 16,
  parameter int KR = 2,
  parameter int KL = 1,
  parameter int KU = 3,
  parameter int KD = 2,
  parameter int NNODE = 2,
  parameter int KLI = 1,
  parameter int KLO = 2,
  parameter int MY_X = 2,
  parameter int MY_Y = 1,
  parameter int CW = 3,
  parameter int NW = 3,
  localparam int NIN  = KR + KL + KU + KD + NNODE * KLI,
  localparam int NOUT = KR + KL + KU + KD + NNODE * KLO,
  localparam int IW = $clog2(NIN),
  localparam int OW = $clog2(NOUT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IW-1:0]     reqInLane,
  input  logic [CW-1:0]     reqDstX,
  input  logic [CW-1:0]     reqDstY,
  input  logic [NW-1:0]     reqDstNode,
  output logic              respGrant,
  output logic              respBusy,
  output logic [OW-1:0]     respOutLane,
  input  logic              relValid,
  input  logic [IW-1:0]     relInLane,
  input  logic [NIN*W-1:0]  inData,
  output logic [NOUT*W-1:0] outData,
  output logic [NOUT-1:0]   outActive
);
  laneStrobe_t    strb;
  logic [NOUT-1:0] outHeld;
  logic [NIN-1:0]  inHeld;

  mesh_lane_switch_ctrl #(
    .KR(KR), .KL(KL), .KU(KU), .KD(KD), .NNODE(NNODE), .KLI(KLI), .KLO(KLO),
    .MY_X(MY_X), .MY_Y(MY_Y), .CW(CW), .NW(NW),
    .NIN(NIN), .NOUT(NOUT), .IW(IW), .OW(OW)
  ) u_ctrl (
    .reqValid(reqValid), .reqInLane(reqInLane), .reqDstX(reqDstX),
    .reqDstY(reqDstY), .reqDstNode(reqDstNode), .relValid(relValid),
    .relInLane(relInLane), .laneFree(~outHeld), .inLaneIdle(~inHeld),
    .respGrant(respGrant), .respBusy(respBusy), .respOutLane(respOutLane),
    .strb(strb)
  );

  mesh_lane_switch_path #(
    .W(W), .NIN(NIN), .NOUT(NOUT), .IW(IW), .OW(OW)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .outData(outData), .outHeld(outHeld), .inHeld(inHeld)
  );

  assign outActive = outHeld;
endmodule

// File: rtl/mesh_lane_switch_chk.sv
module mesh_lane_switch_chk #(
  parameter int NOUT = 12,
  parameter int OW = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            respGrant,
  input logic            respBusy,
  input logic [OW-1:0]   respOutLane,
  input logic [NOUT-1:0] outActive
);
  p_one_response_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones({respGrant, respBusy}) == 1));

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!respGrant && !respBusy));

  p_grant_on_idle_lane_r5: assert property (@(posedge clk) disable iff (!rstN)
    respGrant |-> !outActive[respOutLane]);

  p_grant_reserves_r8: assert property (@(posedge clk) disable iff (!rstN)
    respGrant |=> outActive[$past(respOutLane)]);

  p_busy_adds_nothing_r6: assert property (@(posedge clk) disable iff (!rstN)
    !respGrant |=> ($countones(outActive) <= $countones($past(outActive))));
endmodule

bind mesh_lane_switch mesh_lane_switch_chk #(.NOUT(NOUT), .OW(OW)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .respGrant(respGrant),
  .respBusy(respBusy), .respOutLane(respOutLane), .outActive(outActive)
);

// File: tb/mesh_lane_switch_bench.sv
`timescale 1ns/1ps
module mesh_lane_switch_bench;
  localparam int W = 16, KR = 2, KL = 1, KU = 3, KD = 2;
  localparam int NNODE = 2, KLI = 1, KLO = 2, MX = 2, MY = 1, CW = 3, NW = 3;
  localparam int NIN  = KR + KL + KU + KD + NNODE * KLI;
  localparam int NOUT = KR + KL + KU + KD + NNODE * KLO;
  localparam int IW = $clog2(NIN), OW = $clog2(NOUT);
  localparam int OFF_L = KR, OFF_U = KR + KL, OFF_D = KR + KL + KU, OFF_N = KR + KL + KU + KD;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, relValid = 1'b0;
  logic [IW-1:0] reqInLane = '0, relInLane = '0;
  logic [CW-1:0] reqDstX = '0, reqDstY = '0;
  logic [NW-1:0] reqDstNode = '0;
  logic respGrant, respBusy;
  logic [OW-1:0] respOutLane;
  logic [NIN*W-1:0] inData = '0;
  logic [NOUT*W-1:0] outData;
  logic [NOUT-1:0] outActive;

  always #2 clk = ~clk;

  mesh_lane_switch #(.W(W), .KR(KR), .KL(KL), .KU(KU), .KD(KD), .NNODE(NNODE),
    .KLI(KLI), .KLO(KLO), .MY_X(MX), .MY_Y(MY), .CW(CW), .NW(NW)) u_mesh_lane_switch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqInLane(reqInLane),
    .reqDstX(reqDstX), .reqDstY(reqDstY), .reqDstNode(reqDstNode),
    .respGrant(respGrant), .respBusy(respBusy), .respOutLane(respOutLane),
    .relValid(relValid), .relInLane(relInLane), .inData(inData),
    .outData(outData), .outActive(outActive));

  int checks = 0, fails = 0;
  bit mOut [NOUT];
  int mSrc [NOUT];
  bit mIn  [NIN];
  int mDst [NIN];
  int unsigned seed = 32'h1234_5678;

  function automatic int unsigned nextRand();
    seed = seed * 1664525 + 1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int freeIn(input int base, input int cnt);
    int n = 0;
    for (int o = base; o < base + cnt; o++) if (!mOut[o]) n++;
    return n;
  endfunction

  function automatic int firstIn(input int base, input int cnt);
    for (int o = base; o < base + cnt; o++) if (o < NOUT && !mOut[o]) return o;
    return -1;
  endfunction

  function automatic int portOf(input int lane);
    if (lane < OFF_L) return 0;
    if (lane < OFF_U) return 1;
    if (lane < OFF_D) return 2;
    if (lane < OFF_N) return 3;
    return 4 + (lane - OFF_N) / KLO;
  endfunction

  task automatic resetModel();
    for (int o = 0; o < NOUT; o++) begin mOut[o] = 0; mSrc[o] = 0; end
    for (int i = 0; i < NIN; i++) begin mIn[i] = 0; mDst[i] = 0; end
  endtask

  // one cycle: drive at the falling edge, check combinational response, advance model
  task automatic step(input bit rv, input int lane, input int x, input int y, input int nd,
                      input bit lv, input int rl);
    bit expG;
    int expLane, hb, hc, vb, vc, hf, vf, bse, cnt, p;
    bit hw, vw, ok;
    logic [NOUT*W-1:0] expData;
    string tag;
    @(negedge clk);
    reqValid = rv; reqInLane = IW'(lane); reqDstX = CW'(x); reqDstY = CW'(y);
    reqDstNode = NW'(nd); relValid = lv; relInLane = IW'(rl);
    for (int i = 0; i < NIN; i++) inData[i*W +: W] = W'(nextRand());
    #1;
    expG = 0; expLane = -1; tag = "R6";
    if (lane >= NIN || mIn[lane]) tag = "R10";
    else begin
      hw = (x != MX); vw = (y != MY);
      hb = (x > MX) ? 0 : OFF_L;  hc = (x > MX) ? KR : KL;
      vb = (y > MY) ? OFF_U : OFF_D; vc = (y > MY) ? KU : KD;
      hf = hw ? freeIn(hb, hc) : 0;
      vf = vw ? freeIn(vb, vc) : 0;
      ok = 1; bse = 0; cnt = 0;
      if (!hw && !vw) begin tag = "R7"; ok = nd < NNODE; bse = OFF_N + nd * KLO; cnt = KLO; end
      else if (hf > 0 && hf >= vf) begin tag = "R4"; bse = hb; cnt = hc; end
      else if (vf > 0) begin tag = "R4"; bse = vb; cnt = vc; end
      else ok = 0;
      if (ok) begin
        expLane = firstIn(bse, cnt);
        expG = (expLane >= 0);
      end
    end
    if (rv) begin
      chk(respGrant == expG && respBusy == !expG, {tag, " grant/busy"}, {respGrant, respBusy}, {expG, !expG});
      if (expG && respGrant) begin
        chk(int'(respOutLane) == expLane, "R5 lane choice", respOutLane, expLane);
        p = portOf(int'(respOutLane));
        if (!hw && !vw) ok = (p == 4 + nd);
        else ok = (p == 0 && x > MX) || (p == 1 && x < MX) || (p == 2 && y > MY) || (p == 3 && y < MY);
        chk(ok, "R3 minimal direction", p, -1);
      end
    end else begin
      chk(!respGrant && !respBusy, "R2 silent without request", {respGrant, respBusy}, 0);
    end
    expData = '0;
    for (int o = 0; o < NOUT; o++) if (mOut[o]) expData[o*W +: W] = inData[mSrc[o]*W +: W];
    chk(outData == expData, "R8 lane data", outData, expData);
    // model advances at the coming rising edge
    if (lv && rl < NIN && mIn[rl]) begin mOut[mDst[rl]] = 0; mIn[rl] = 0; end
    if (rv && expG) begin mOut[expLane] = 1; mSrc[expLane] = lane; mIn[lane] = 1; mDst[lane] = expLane; end
  endtask

  task automatic releaseAll();
    for (int i = 0; i < NIN; i++) if (mIn[i]) step(0, 0, 0, 0, 0, 1, i);
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    resetModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outActive == '0, "R1 reset lanes idle", outActive, 0);
    chk(outData == '0, "R1 reset data zero", outData, 0);
    rstN = 1'b1;

    // local delivery, exhaustion, release timing (R7, R6, R9)
    step(1, 8, MX, MY, 0, 0, 0);
    chk(respOutLane == OW'(8), "R7 first node lane", respOutLane, 8);
    step(1, 9, MX, MY, 0, 0, 0);
    step(1, 0, MX, MY, 0, 0, 0);
    chk(respBusy == 1'b1, "R6 node port full", respBusy, 1);
    step(1, 0, MX, MY, 0, 1, 8);
    chk(respBusy == 1'b1, "R9 release not yet visible", respBusy, 1);
    step(1, 0, MX, MY, 0, 0, 0);
    chk(respGrant == 1'b1 && respOutLane == OW'(8), "R9 lane free after release", respOutLane, 8);
    step(1, 1, MX, MY, 5, 0, 0);
    chk(respBusy == 1'b1, "R7 node index out of range", respBusy, 1);
    step(0, 0, 0, 0, 0, 1, 3);
    chk(outActive == 12'h300, "R9 idle release ignored", outActive, 12'h300);
    step(1, 0, MX + 1, MY, 0, 0, 0);
    chk(respBusy == 1'b1, "R10 held input lane", respBusy, 1);
    step(1, NIN, MX + 1, MY, 0, 0, 0);
    chk(respBusy == 1'b1, "R10 invalid input lane", respBusy, 1);
    releaseAll();

    // load choice and tie (R4): up has 3 idle, right 2, then 2 against 2
    step(1, 0, MX + 1, MY + 1, 0, 0, 0);
    chk(respOutLane == OW'(OFF_U), "R4 more idle lanes wins", respOutLane, OFF_U);
    step(1, 1, MX + 1, MY + 1, 0, 0, 0);
    chk(respOutLane == OW'(0), "R4 tie goes horizontal", respOutLane, 0);
    step(1, 2, MX + 1, MY + 1, 0, 0, 0);
    step(1, 3, MX + 1, MY + 1, 0, 0, 0);
    step(1, 4, MX + 1, MY + 1, 0, 0, 0);
    step(1, 5, MX + 1, MY + 1, 0, 0, 0);
    chk(respBusy == 1'b1, "R6 all candidates full", respBusy, 1);
    chk(outActive == 12'h03B, "R6 no partial reservation", outActive, 12'h03B);
    releaseAll();

    // sweep every destination from an empty switch
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++)
        for (int nd = 0; nd < 3; nd++) begin
          step(1, (x + y + nd) % NIN, x, y, nd, 0, 0);
          releaseAll();
        end

    // long mixed run of requests and releases
    for (int n = 0; n < 6000; n++) begin
      int unsigned r1, r2;
      r1 = nextRand(); r2 = nextRand();
      step((r1 % 4) != 0, int'(r1 % (NIN + 1)), int'((r1 >> 5) % 8), int'((r1 >> 9) % 8),
           int'((r1 >> 13) % 3), (r2 % 3) == 0, int'((r2 >> 4) % NIN));
    end

    @(negedge clk);
    reqValid = 0; relValid = 0;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule